// File: doc/BRIEF.md
# User-Readable Hardware Register Unit

This block executes a 32-bit extended compact instruction that copies one of a small set of hardware registers into a general purpose register. It decodes the instruction word and decides whether the read is permitted. Each valid read produces one of two results: a write of the register's value to a translated GPR index, or a reserved-instruction exception.

Alongside the decoder, the unit holds the readable state. A free-running cycle counter advances once every `CC_RES` clocks. A 32-bit user-local register is written through a dedicated privileged port. The CPU number, cache sync step, counter resolution, double-width atomic capability flag and the two implementation-dependent values are fixed by parameters.

A read is permitted when the privileged enable is high, or when the mask bit indexed by the register number is set. Reserved numbers trap in every mode, and so do implementation-dependent numbers that are configured off. The result appears one clock after the valid strobe.

Top module: `hwreg_read_unit`

## Requirements
- R1: The block acts only on a word whose fields match exactly. Bits [31:27] must be 11110 and bits [26:21] must be zero. Bits [15:11] must be 00110 and bits [10:8] must be zero. Bits [4:2] must equal 3 and bits [1:0] must be 00. The register number is bits [20:16] and ry is bits [7:5]. Any other word, or a matching word without `instr_valid`, leaves `rd_we` and `ri_exc` low.
- R2: Each result is registered and appears in the cycle after the `instr_valid` strobe, as a single-cycle pulse. `rd_we` and `ri_exc` are never high together. After reset both are low, and `rd_data` and `rd_gpr` are zero.
- R3: On a write, `rd_gpr` is the translated ry: 0 gives 16, 1 gives 17, and 2 to 7 map to themselves.
- R4: Register 0 returns `CPU_NUM`. Register 1 returns `SYNC_STEP`. Register 3 returns `CC_RES`. Register 5 returns the capability flag `XNP_FLAG`, where 1 means double-width linked load/store is absent.
- R5: Register numbers 4 and 6 through 28 raise `ri_exc` with no write, even with privileged enable.
- R6: Register 30 (or 31) returns `IMPL30_VAL` (`IMPL31_VAL`) when `IMPL30_EN` (`IMPL31_EN`) is 1. When the enable is 0, a read raises `ri_exc`.
- R7: A read of an implemented register is allowed when `priv_en` is 1 or when `user_en_mask[n]` is 1, with n the register number. Otherwise `ri_exc` is raised and nothing is written.
- R8: The cycle counter resets to zero and increments once every `CC_RES` clocks. Reads issued K·`CC_RES` cycles apart differ by exactly K.
- R9: Register 2 returns the cycle counter value at the strobe cycle.
- R10: The user-local register resets to zero and loads `ulr_wr_data` on a clock with `ulr_wr_en`. Register 29 returns its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Strobe qualifying `instr_word` |
| instr_word | input | 32 | Instruction, first halfword in [31:16] |
| priv_en | input | 1 | Privileged / coprocessor-enabled state |
| user_en_mask | input | 32 | Per-register user access enables |
| ulr_wr_en | input | 1 | Privileged write strobe for user-local register |
| ulr_wr_data | input | 32 | Data for user-local register |
| rd_gpr | output | 5 | Destination GPR index |
| rd_data | output | 32 | Value read |
| rd_we | output | 1 | GPR write enable pulse |
| ri_exc | output | 1 | Reserved-instruction exception pulse |

## Verification
The bound checker covers several properties on every cycle:
- `rd_we` and `ri_exc` are mutually exclusive, and both follow a strobe.
- Non-matching words stay silent, while reserved numbers and denied accesses trap.
- Written GPR indices stay inside the translation range.
- The counter never steps by more than one.
- The user-local register captures its write port.

Only the directed scenarios can show the actual values returned per register, the exact counter rate over a measured window, and the mapping of each ry code.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

   localparam int WORD_W = 32;
   localparam int NUM_W  = 5;
   localparam int RY_W   = 3;
   localparam int GPR_W  = 5;

   localparam logic [4:0] EXT_PREFIX  = 5'b11110;
   localparam logic [4:0] MAJOR_OP    = 5'b00110;
   localparam logic [2:0] SEL_CODE    = 3'd3;
   localparam logic [1:0] FUNC_CODE   = 2'b00;

   localparam logic [NUM_W-1:0] N_CPU    = 5'd0;
   localparam logic [NUM_W-1:0] N_STEP   = 5'd1;
   localparam logic [NUM_W-1:0] N_COUNT  = 5'd2;
   localparam logic [NUM_W-1:0] N_RES    = 5'd3;
   localparam logic [NUM_W-1:0] N_CAP    = 5'd5;
   localparam logic [NUM_W-1:0] N_LOCAL  = 5'd29;
   localparam logic [NUM_W-1:0] N_IMP_A  = 5'd30;
   localparam logic [NUM_W-1:0] N_IMP_B  = 5'd31;

   typedef struct packed {
      logic             hit;
      logic [NUM_W-1:0] num;
      logic [RY_W-1:0]  ry;
   } hwr_dec_t;

   function automatic logic [GPR_W-1:0] ry_to_gpr(input logic [RY_W-1:0] ry);
      logic [GPR_W-1:0] idx;
      case (ry)
         3'd0:    idx = 5'd16;
         3'd1:    idx = 5'd17;
         default: idx = {2'b00, ry};
      endcase
      return idx;
   endfunction

endpackage

// File: rtl/hwr_decode.sv
module hwr_decode
   import hwr_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output hwr_dec_t          dec
);

   logic hi_ok;
   logic lo_ok;

   always_comb begin
      hi_ok = (word[31:27] == EXT_PREFIX) && (word[26:21] == 6'd0);
      lo_ok = (word[15:11] == MAJOR_OP) && (word[10:8] == 3'd0) &&
              (word[4:2] == SEL_CODE) && (word[1:0] == FUNC_CODE);
      dec.hit = hi_ok && lo_ok;
      dec.num = word[20:16];
      dec.ry  = word[7:5];
   end

endmodule

// File: rtl/hwr_cycle_ctr.sv
module hwr_cycle_ctr #(
   parameter int CNT_W  = 32,
   parameter int CC_RES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count
);

   localparam int PS_W = (CC_RES > 1) ? $clog2(CC_RES) : 1;

   logic step;

   generate
      if (CC_RES < 1) begin : g_bad_res
         $error("hwr_cycle_ctr: CC_RES must be at least 1");
      end

      if (CC_RES == 1) begin : g_every_cycle
         assign step = 1'b1;
      end else begin : g_prescaled
         logic [PS_W-1:0] ps;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ps <= '0;
            end else if (ps == PS_W'(CC_RES - 1)) begin
               ps <= '0;
            end else begin
               ps <= ps + 1'b1;
            end
         end
         assign step = (ps == PS_W'(CC_RES - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (step) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/hwr_source_mux.sv
module hwr_source_mux
   import hwr_pkg::*;
#(
   parameter logic [WORD_W-1:0] CPU_NUM    = 32'd0,
   parameter logic [WORD_W-1:0] SYNC_STEP  = 32'd32,
   parameter int                CC_RES     = 3,
   parameter bit                XNP_FLAG   = 1'b1,
   parameter bit                IMPL30_EN  = 1'b1,
   parameter logic [WORD_W-1:0] IMPL30_VAL = 32'h0,
   parameter bit                IMPL31_EN  = 1'b0,
   parameter logic [WORD_W-1:0] IMPL31_VAL = 32'h0
) (
   input  logic [NUM_W-1:0]  num,
   input  logic [WORD_W-1:0] count,
   input  logic [WORD_W-1:0] local_val,
   output logic [WORD_W-1:0] value,
   output logic              present
);

   localparam logic [WORD_W-1:0] RES_VAL = WORD_W'(CC_RES);
   localparam logic [WORD_W-1:0] CAP_VAL = {{(WORD_W-1){1'b0}}, XNP_FLAG};

   always_comb begin
      value   = '0;
      present = 1'b1;
      case (num)
         N_CPU:   value = CPU_NUM;
         N_STEP:  value = SYNC_STEP;
         N_COUNT: value = count;
         N_RES:   value = RES_VAL;
         N_CAP:   value = CAP_VAL;
         N_LOCAL: value = local_val;
         N_IMP_A: begin
            present = IMPL30_EN;
            value   = IMPL30_EN ? IMPL30_VAL : '0;
         end
         N_IMP_B: begin
            present = IMPL31_EN;
            value   = IMPL31_EN ? IMPL31_VAL : '0;
         end
         default: present = 1'b0;
      endcase
   end

endmodule

// File: rtl/hwreg_read_unit.sv
module hwreg_read_unit
   import hwr_pkg::*;
#(
   parameter logic [31:0] CPU_NUM    = 32'd3,
   parameter logic [31:0] SYNC_STEP  = 32'd64,
   parameter int          CC_RES     = 3,
   parameter bit          XNP_FLAG   = 1'b1,
   parameter bit          IMPL30_EN  = 1'b1,
   parameter logic [31:0] IMPL30_VAL = 32'hC0DE_0030,
   parameter bit          IMPL31_EN  = 1'b0,
   parameter logic [31:0] IMPL31_VAL = 32'hC0DE_0031
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        instr_valid,
   input  logic [31:0] instr_word,
   input  logic        priv_en,
   input  logic [31:0] user_en_mask,
   input  logic        ulr_wr_en,
   input  logic [31:0] ulr_wr_data,
   output logic [4:0]  rd_gpr,
   output logic [31:0] rd_data,
   output logic        rd_we,
   output logic        ri_exc
);

   hwr_dec_t           dec;
   logic [WORD_W-1:0]  cc_count;
   logic [WORD_W-1:0]  ulr_q;
   logic [WORD_W-1:0]  src_val;
   logic               src_present;
   logic               permitted;
   logic               grant;

   hwr_decode u_decode (
      .word (instr_word),
      .dec  (dec)
   );

   hwr_cycle_ctr #(
      .CNT_W  (WORD_W),
      .CC_RES (CC_RES)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .count (cc_count)
   );

   hwr_source_mux #(
      .CPU_NUM    (CPU_NUM),
      .SYNC_STEP  (SYNC_STEP),
      .CC_RES     (CC_RES),
      .XNP_FLAG   (XNP_FLAG),
      .IMPL30_EN  (IMPL30_EN),
      .IMPL30_VAL (IMPL30_VAL),
      .IMPL31_EN  (IMPL31_EN),
      .IMPL31_VAL (IMPL31_VAL)
   ) u_mux (
      .num       (dec.num),
      .count     (cc_count),
      .local_val (ulr_q),
      .value     (src_val),
      .present   (src_present)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ulr_q <= '0;
      end else if (ulr_wr_en) begin
         ulr_q <= ulr_wr_data;
      end
   end

   always_comb begin
      permitted = priv_en || user_en_mask[dec.num];
      grant     = src_present && permitted;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_we   <= 1'b0;
         ri_exc  <= 1'b0;
         rd_data <= '0;
         rd_gpr  <= '0;
      end else begin
         rd_we  <= 1'b0;
         ri_exc <= 1'b0;
         if (instr_valid && dec.hit) begin
            if (grant) begin
               rd_we   <= 1'b1;
               rd_data <= src_val;
               rd_gpr  <= ry_to_gpr(dec.ry);
            end else begin
               ri_exc  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/hwreg_read_unit_chk.sv
module hwreg_read_unit_chk #(
   parameter bit IMPL30_EN = 1'b1,
   parameter bit IMPL31_EN = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        instr_valid,
   input logic [31:0] instr_word,
   input logic        priv_en,
   input logic [31:0] user_en_mask,
   input logic        ulr_wr_en,
   input logic [31:0] ulr_wr_data,
   input logic [4:0]  rd_gpr,
   input logic        rd_we,
   input logic        ri_exc,
   input logic [31:0] cc_count,
   input logic [31:0] ulr_q
);

   logic       started;
   logic       w_hit;
   logic [4:0] w_num;
   logic       w_rsvd;
   logic       w_absent;

   always_ff @(posedge clk) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   always_comb begin
      w_hit = (instr_word[31:21] == 11'b11110_000000) &&
              (instr_word[15:8] == 8'b00110_000) &&
              (instr_word[4:0] == 5'b011_00);
      w_num = instr_word[20:16];
      w_rsvd = (w_num == 5'd4) || ((w_num >= 5'd6) && (w_num <= 5'd28));
      w_absent = w_rsvd || ((w_num == 5'd30) && !IMPL30_EN) ||
                 ((w_num == 5'd31) && !IMPL31_EN);
   end

   // R2
   excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_we && ri_exc));

   // R2
   needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && (rd_we || ri_exc)) |-> $past(instr_valid));

   // R1
   silent_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !w_hit) |=> (!rd_we && !ri_exc));

   // R5
   rsvd_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && w_hit && w_rsvd) |=> ri_exc);

   // R7
   denied_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && w_hit && !priv_en && !user_en_mask[w_num]) |=> ri_exc);

   // R6
   absent_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && w_hit && w_absent) |=> !rd_we);

   // R3
   gpr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> ((rd_gpr >= 5'd2 && rd_gpr <= 5'd7) || rd_gpr == 5'd16 || rd_gpr == 5'd17));

   // R8
   ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (cc_count == $past(cc_count) || cc_count == $past(cc_count) + 32'd1));

   // R10
   ulr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(ulr_wr_en)) |-> (ulr_q == $past(ulr_wr_data)));

endmodule

bind hwreg_read_unit hwreg_read_unit_chk #(
   .IMPL30_EN (IMPL30_EN),
   .IMPL31_EN (IMPL31_EN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .instr_valid  (instr_valid),
   .instr_word   (instr_word),
   .priv_en      (priv_en),
   .user_en_mask (user_en_mask),
   .ulr_wr_en    (ulr_wr_en),
   .ulr_wr_data  (ulr_wr_data),
   .rd_gpr       (rd_gpr),
   .rd_we        (rd_we),
   .ri_exc       (ri_exc),
   .cc_count     (cc_count),
   .ulr_q        (ulr_q)
);

// File: tb/hwreg_read_unit_bench.sv
module hwreg_read_unit_bench;

   localparam logic [31:0] P_CPU  = 32'd3;
   localparam logic [31:0] P_STEP = 32'd64;
   localparam int          P_RES  = 3;
   localparam bit          P_XNP  = 1'b1;
   localparam logic [31:0] P_I30  = 32'hC0DE_0030;
   localparam logic [31:0] P_I31  = 32'hC0DE_0031;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic        priv_en = 1'b0;
   logic [31:0] user_en_mask = '0;
   logic        ulr_wr_en = 1'b0;
   logic [31:0] ulr_wr_data = '0;
   logic [4:0]  rd_gpr;
   logic [31:0] rd_data;
   logic        rd_we;
   logic        ri_exc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic        o_we, o_exc;
   logic [31:0] o_data;
   logic [4:0]  o_gpr;

   hwreg_read_unit #(
      .CPU_NUM (P_CPU), .SYNC_STEP (P_STEP), .CC_RES (P_RES), .XNP_FLAG (P_XNP),
      .IMPL30_EN (1'b1), .IMPL30_VAL (P_I30), .IMPL31_EN (1'b0), .IMPL31_VAL (P_I31)
   ) u_hwreg_read_unit (
      .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr_word (instr_word),
      .priv_en (priv_en), .user_en_mask (user_en_mask), .ulr_wr_en (ulr_wr_en),
      .ulr_wr_data (ulr_wr_data), .rd_gpr (rd_gpr), .rd_data (rd_data),
      .rd_we (rd_we), .ri_exc (ri_exc)
   );

   always #4 clk = ~clk;

   function automatic logic [31:0] mk(input logic [4:0] n, input logic [2:0] ry);
      return {5'b11110, 5'b00000, 1'b0, n, 5'b00110, 3'b000, ry, 3'd3, 2'b00};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] w, input logic pv, input logic [31:0] m);
      instr_word = w; priv_en = pv; user_en_mask = m; instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      o_we = rd_we; o_exc = ri_exc; o_data = rd_data; o_gpr = rd_gpr;
   endtask

   task automatic expect_val(input logic [31:0] w, input logic pv, input logic [31:0] m,
                             input logic [31:0] exp, input string tag);
      issue(w, pv, m);
      chk(o_we && !o_exc, tag, {o_we, o_exc}, 32'h2);
      chk(o_data == exp, tag, o_data, exp);
   endtask

   task automatic expect_trap(input logic [31:0] w, input logic pv, input logic [31:0] m, input string tag);
      issue(w, pv, m);
      chk(!o_we && o_exc, tag, {o_we, o_exc}, 32'h1);
   endtask

   task automatic t_reset();
      chk(!rd_we && !ri_exc && rd_data == 0 && rd_gpr == 0, "R2 reset", {rd_we, ri_exc}, 0);
      @(negedge clk);
      chk(!rd_we && !ri_exc, "R2 idle", {rd_we, ri_exc}, 0);
   endtask

   task automatic t_fixed();
      expect_val(mk(5'd0, 3'd2), 1'b1, 0, P_CPU, "R4 cpu");
      expect_val(mk(5'd1, 3'd2), 1'b1, 0, P_STEP, "R4 step");
      expect_val(mk(5'd3, 3'd2), 1'b1, 0, 32'(P_RES), "R4 res");
      expect_val(mk(5'd5, 3'd2), 1'b1, 0, {31'd0, P_XNP}, "R4 cap");
      @(negedge clk);
      chk(!rd_we && !ri_exc, "R2 pulse", {rd_we, ri_exc}, 0);
   endtask

   task automatic t_ry();
      for (int r = 0; r < 8; r++) begin
         logic [4:0] e;
         e = (r == 0) ? 5'd16 : (r == 1) ? 5'd17 : 5'(r);
         issue(mk(5'd0, 3'(r)), 1'b1, 0);
         chk(o_we && o_gpr == e, "R3 ry map", {27'd0, o_gpr}, {27'd0, e});
      end
   endtask

   task automatic t_reserved();
      expect_trap(mk(5'd4, 3'd2), 1'b1, 32'hFFFF_FFFF, "R5 n4");
      expect_trap(mk(5'd6, 3'd2), 1'b1, 32'hFFFF_FFFF, "R5 n6");
      expect_trap(mk(5'd28, 3'd2), 1'b1, 32'hFFFF_FFFF, "R5 n28");
      expect_trap(mk(5'd17, 3'd2), 1'b0, 32'hFFFF_FFFF, "R5 n17 user");
   endtask

   task automatic t_impl();
      expect_val(mk(5'd30, 3'd3), 1'b1, 0, P_I30, "R6 n30");
      expect_trap(mk(5'd31, 3'd3), 1'b1, 32'hFFFF_FFFF, "R6 n31");
   endtask

   task automatic t_access();
      expect_trap(mk(5'd0, 3'd4), 1'b0, 32'h0, "R7 no mask");
      expect_trap(mk(5'd0, 3'd4), 1'b0, 32'hFFFF_FFFE, "R7 other bits");
      expect_val(mk(5'd0, 3'd4), 1'b0, 32'h1, P_CPU, "R7 mask bit0");
      expect_val(mk(5'd30, 3'd4), 1'b0, 32'h4000_0000, P_I30, "R7 mask bit30");
      expect_trap(mk(5'd1, 3'd4), 1'b0, 32'h1, "R7 wrong bit");
   endtask

   task automatic t_decode();
      logic [31:0] good;
      good = mk(5'd0, 3'd2);
      issue(good ^ 32'h8000_0000, 1'b1, 0);
      chk(!o_we && !o_exc, "R1 prefix", {o_we, o_exc}, 0);
      issue(good | 32'h0020_0000, 1'b1, 0);
      chk(!o_we && !o_exc, "R1 zero bit", {o_we, o_exc}, 0);
      issue(good ^ 32'h0000_0800, 1'b1, 0);
      chk(!o_we && !o_exc, "R1 opcode", {o_we, o_exc}, 0);
      issue(good | 32'h0000_0100, 1'b1, 0);
      chk(!o_we && !o_exc, "R1 lo zero", {o_we, o_exc}, 0);
      issue({good[31:5], 3'd2, 2'b00}, 1'b1, 0);
      chk(!o_we && !o_exc, "R1 sel", {o_we, o_exc}, 0);
      issue(good | 32'h1, 1'b1, 0);
      chk(!o_we && !o_exc, "R1 func", {o_we, o_exc}, 0);
      issue(mk(5'd4, 3'd2) | 32'h1, 1'b1, 0);
      chk(!o_we && !o_exc, "R1 rsvd miss", {o_we, o_exc}, 0);
      instr_word = good; priv_en = 1'b1;
      @(negedge clk);
      chk(!rd_we && !ri_exc, "R1 no strobe", {rd_we, ri_exc}, 0);
   endtask

   task automatic t_counter();
      logic [31:0] a, b;
      issue(mk(5'd2, 3'd5), 1'b1, 0);
      a = o_data;
      repeat (29) @(negedge clk);
      issue(mk(5'd2, 3'd5), 1'b0, 32'h4);
      b = o_data;
      chk(o_we, "R9 count read", {31'd0, o_we}, 1);
      chk(b - a == 32'd10, "R8 rate 30 cycles", b - a, 32'd10);
      repeat (2) @(negedge clk);
      issue(mk(5'd2, 3'd5), 1'b1, 0);
      a = o_data;
      repeat (2) @(negedge clk);
      issue(mk(5'd2, 3'd5), 1'b1, 0);
      chk(o_data - a == 32'd1, "R8 rate 3 cycles", o_data - a, 32'd1);
   endtask

   task automatic t_ulr();
      expect_val(mk(5'd29, 3'd6), 1'b1, 0, 32'd0, "R10 reset");
      ulr_wr_data = 32'h1234_ABCD; ulr_wr_en = 1'b1;
      @(negedge clk);
      ulr_wr_en = 1'b0; ulr_wr_data = 32'hFFFF_0000;
      expect_val(mk(5'd29, 3'd6), 1'b0, 32'h2000_0000, 32'h1234_ABCD, "R10 written");
      @(negedge clk);
      expect_val(mk(5'd29, 3'd6), 1'b1, 0, 32'h1234_ABCD, "R10 held");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      issue(mk(5'd2, 3'd2), 1'b1, 0);
      chk(o_we && o_data < 32'd3, "R8 reset zero", o_data, 32'd0);
      t_fixed();
      t_ry();
      t_reserved();
      t_impl();
      t_access();
      t_decode();
      t_counter();
      t_ulr();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule